// File: doc/BRIEF.md
# Rectifier Sextant Gate Selector

This block drives the three bidirectional switches of a unidirectional current-source rectifier that feeds an inverter over a dc link with no storage element. Each carrier period uses the two active rectifier states that lie nearest the input current reference. The switch of the phase with the largest magnitude stays on, tied to one rail for the whole sextant. The other rail goes to one of the two remaining switches while the carrier rises and to the other while it falls. The carrier is built so that its rising and falling durations equal the two rectifier duties. Because of that, a change of state lands only at a carrier turning point, where the inverter sits in its all-zero state and the link carries no current.

A controller elsewhere supplies the sextant number, 0 to 5, with sextant 0 centred on the peak of phase a. The carrier modulator supplies a flag that is high while the carrier rises. The block registers a new sextant only at a carrier trough, so a period never mixes two sextants. It also reports the active state as a code and flags sextant values that have no meaning.

Top module: `rect_sextant_gate_sel`

## Requirements
- R1: `gate_on` (bit 0 phase a, bit 1 phase b, bit 2 phase c) is either all zero or has exactly two bits set; a single-switch null state never appears.
- R2: With latched sextant s, `state_code` is s+1 while the carrier rises and s+2 while it falls, and 7 wraps to 1. The codes mean: 1 = a on positive rail and b on negative, 2 = a+/c-, 3 = b+/c-, 4 = b+/a-, 5 = c+/a-, 6 = c+/b-. The gates set are the two phases of that pair.
- R3: Even sextants clamp a switch to the positive rail and odd sextants clamp one to the negative rail. The clamped switch stays on through both halves of the period, and the clamp rotates a, c, b, a, c, b over sextants 0 to 5.
- R4: The `sextant` input is latched only at a carrier trough, which is a cycle with `carrier_rising` high after a cycle with it low. A new value applied at any other time has no effect until the next trough.
- R5: The outputs are registered and follow the inputs one clock later. `gate_on` and `state_code` change only when `carrier_rising` changes, when the latched sextant becomes valid or invalid at a trough, or when `enable` changes.
- R6: `state_code` is 0 exactly when all gates are off.
- R7: With `enable` low, all gates are off and `sextant_err` is low from the next clock on. After `enable` returns, the gates stay off until the next carrier trough.
- R8: A latched sextant value of 6 or 7 turns all gates off and raises `sextant_err`. The flag clears at the first trough that latches a value from 0 to 5.
- R9: After reset, the gates, the code and the error flag are zero until the first carrier trough with `enable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows gate drive when high |
| carrier_rising | input | 1 | High while the carrier slope rises |
| sextant | input | 3 | Input reference sextant, 0 to 5 |
| gate_on | output | 3 | Gate drive for phases a, b, c |
| state_code | output | 3 | Active rectifier state, 1 to 6, or 0 when off |
| sextant_err | output | 1 | Latched sextant value is out of range |

## Verification
The block has no parameters that change its behaviour. The bench builds it with the package values: three phases, a 3-bit sextant field and six valid sextants. With these values, all six sextants in both carrier halves can be covered in a few dozen cycles, and so can both values outside the range. The cases at the edges are checked as well: a sextant changed in the middle of a period, a trough reached while disabled, and a re-enable while the carrier is already rising.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int PHASES   = 3;
    localparam int NUM_SEXT = 6;
    localparam int SEXT_W   = $clog2(NUM_SEXT + 1);
    localparam int CODE_W   = $clog2(2 * PHASES + 1);
    localparam int IDX_W    = $clog2(PHASES);

    typedef struct packed {
        logic [SEXT_W-1:0] sext;
        logic              armed;
        logic [PHASES-1:0] gates;
        logic [CODE_W-1:0] code;
        logic              err;
    } sel_reg_t;
endpackage

// File: rtl/rsg_turn_detect.sv
module rsg_turn_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rising_i,
    output logic trough_o
);
    logic dir_d, dir_q;

    always_comb begin
        dir_d    = rising_i;
        trough_o = rising_i & ~dir_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= 1'b1;
        else        dir_q <= dir_d;
    end
endmodule

// File: rtl/rsg_state_decode.sv
module rsg_state_decode
    import rsg_pkg::*;
(
    input  logic [SEXT_W-1:0] sext_i,
    input  logic              rising_i,
    output logic [PHASES-1:0] gate_o,
    output logic [CODE_W-1:0] code_o
);
    logic [IDX_W-1:0] clamp_idx, mod_idx;

    always_comb begin
        int unsigned s, c, m, p, n;
        logic even;
        s    = int'(sext_i);
        c    = (PHASES - (s % PHASES)) % PHASES;
        m    = rising_i ? (c + 1) % PHASES : (c + 2) % PHASES;
        even = (s % 2) == 0;
        p    = even ? c : m;
        n    = even ? m : c;
        clamp_idx = IDX_W'(c);
        mod_idx   = IDX_W'(m);
        code_o    = CODE_W'(1 + 2 * p + ((n == (p + 1) % PHASES) ? 0 : 1));
    end

    for (genvar g = 0; g < PHASES; g++) begin : g_leg
        assign gate_o[g] = (clamp_idx == IDX_W'(g)) || (mod_idx == IDX_W'(g));
    end
endmodule

// File: rtl/rect_sextant_gate_sel.sv
module rect_sextant_gate_sel
    import rsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              carrier_rising,
    input  logic [SEXT_W-1:0] sextant,
    output logic [PHASES-1:0] gate_on,
    output logic [CODE_W-1:0] state_code,
    output logic              sextant_err
);
    sel_reg_t          cur_q, nxt_d;
    logic              trough;
    logic [SEXT_W-1:0] sext_use;
    logic              armed_use, valid;
    logic [PHASES-1:0] dec_gates;
    logic [CODE_W-1:0] dec_code;

    rsg_turn_detect i_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .rising_i (carrier_rising),
        .trough_o (trough)
    );

    rsg_state_decode i_decode (
        .sext_i   (sext_use),
        .rising_i (carrier_rising),
        .gate_o   (dec_gates),
        .code_o   (dec_code)
    );

    always_comb begin
        nxt_d     = cur_q;
        sext_use  = trough ? sextant : cur_q.sext;
        armed_use = enable && (cur_q.armed || trough);
        valid     = int'(sext_use) < NUM_SEXT;

        nxt_d.sext  = sext_use;
        nxt_d.armed = armed_use;
        nxt_d.err   = armed_use && !valid;
        if (armed_use && valid) begin
            nxt_d.gates = dec_gates;
            nxt_d.code  = dec_code;
        end else begin
            nxt_d.gates = '0;
            nxt_d.code  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign gate_on     = cur_q.gates;
    assign state_code  = cur_q.code;
    assign sextant_err = cur_q.err;
endmodule

// File: rtl/rsg_gate_sel_chk.sv
module rsg_gate_sel_chk
    import rsg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              carrier_rising,
    input logic [PHASES-1:0] gate_on,
    input logic [CODE_W-1:0] state_code,
    input logic              sextant_err
);
    a_r1_pair_or_off: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on == '0) || ($countones(gate_on) == 2));

    a_r6_code_tracks_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == '0) == (gate_on == '0));

    a_r5_hold_between_turns: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (carrier_rising == $past(carrier_rising)))
        |=> ($stable(gate_on) && $stable(state_code)));

    a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((gate_on == '0) && !sextant_err));

    a_r8_err_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        sextant_err |-> ((gate_on == '0) && (state_code == '0)));
endmodule

bind rect_sextant_gate_sel rsg_gate_sel_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .carrier_rising (carrier_rising),
    .gate_on        (gate_on),
    .state_code     (state_code),
    .sextant_err    (sextant_err)
);

// File: tb/test_rect_sextant_gate_sel.sv
module test_rect_sextant_gate_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       carrier_rising = 1'b0;
    logic [2:0] sextant = 3'd0;
    logic [2:0] gate_on;
    logic [2:0] state_code;
    logic       sextant_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rect_sextant_gate_sel i_rect_sextant_gate_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .carrier_rising (carrier_rising),
        .sextant        (sextant),
        .gate_on        (gate_on),
        .state_code     (state_code),
        .sextant_err    (sextant_err)
    );

    // entry: req id, enable, rising, sextant, exp gates, exp code, exp err
    localparam int NV = 27;
    localparam logic [15:0] VEC [NV] = '{
        {4'd9, 1'b1, 1'b0, 3'd0, 3'b000, 3'd0, 1'b0},
        {4'd2, 1'b1, 1'b1, 3'd0, 3'b011, 3'd1, 1'b0},
        {4'd2, 1'b1, 1'b0, 3'd0, 3'b101, 3'd2, 1'b0},
        {4'd3, 1'b1, 1'b1, 3'd1, 3'b101, 3'd2, 1'b0},
        {4'd3, 1'b1, 1'b0, 3'd1, 3'b110, 3'd3, 1'b0},
        {4'd2, 1'b1, 1'b1, 3'd2, 3'b110, 3'd3, 1'b0},
        {4'd2, 1'b1, 1'b0, 3'd2, 3'b011, 3'd4, 1'b0},
        {4'd3, 1'b1, 1'b1, 3'd3, 3'b011, 3'd4, 1'b0},
        {4'd3, 1'b1, 1'b0, 3'd3, 3'b101, 3'd5, 1'b0},
        {4'd2, 1'b1, 1'b1, 3'd4, 3'b101, 3'd5, 1'b0},
        {4'd2, 1'b1, 1'b0, 3'd4, 3'b110, 3'd6, 1'b0},
        {4'd3, 1'b1, 1'b1, 3'd5, 3'b110, 3'd6, 1'b0},
        {4'd2, 1'b1, 1'b0, 3'd5, 3'b011, 3'd1, 1'b0},
        {4'd4, 1'b1, 1'b1, 3'd0, 3'b011, 3'd1, 1'b0},
        {4'd4, 1'b1, 1'b1, 3'd3, 3'b011, 3'd1, 1'b0},
        {4'd4, 1'b1, 1'b0, 3'd3, 3'b101, 3'd2, 1'b0},
        {4'd4, 1'b1, 1'b1, 3'd3, 3'b011, 3'd4, 1'b0},
        {4'd8, 1'b1, 1'b0, 3'd6, 3'b101, 3'd5, 1'b0},
        {4'd8, 1'b1, 1'b1, 3'd6, 3'b000, 3'd0, 1'b1},
        {4'd8, 1'b1, 1'b0, 3'd7, 3'b000, 3'd0, 1'b1},
        {4'd8, 1'b1, 1'b1, 3'd2, 3'b110, 3'd3, 1'b0},
        {4'd7, 1'b0, 1'b0, 3'd2, 3'b000, 3'd0, 1'b0},
        {4'd7, 1'b0, 1'b1, 3'd7, 3'b000, 3'd0, 1'b0},
        {4'd7, 1'b1, 1'b1, 3'd2, 3'b000, 3'd0, 1'b0},
        {4'd7, 1'b1, 1'b0, 3'd2, 3'b000, 3'd0, 1'b0},
        {4'd7, 1'b1, 1'b1, 3'd2, 3'b110, 3'd3, 1'b0},
        {4'd5, 1'b1, 1'b1, 3'd2, 3'b110, 3'd3, 1'b0}
    };

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_out(input string req, input logic [2:0] g,
                             input logic [2:0] c, input logic e);
        checks++;
        if (gate_on !== g || state_code !== c || sextant_err !== e) begin
            errors++;
            $display("FAIL %s: gates=%b code=%0d err=%b, expected gates=%b code=%0d err=%b",
                     req, gate_on, state_code, sextant_err, g, c, e);
        end
    endtask

    task automatic check_shape();
        // R1: zero or exactly two gates; R6: code zero exactly when gates off
        checks++;
        if (!(gate_on == 3'b000 || $countones(gate_on) == 2)) begin
            errors++;
            $display("FAIL R1: gates=%b, expected 000 or two bits set", gate_on);
        end
        checks++;
        if ((state_code == 3'd0) != (gate_on == 3'b000)) begin
            errors++;
            $display("FAIL R6: code=%0d gates=%b, expected code 0 only with gates off",
                     state_code, gate_on);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R9", 3'b000, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R9", 3'b000, 3'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            enable         = VEC[i][11];
            carrier_rising = VEC[i][10];
            sextant        = VEC[i][9:7];
            @(negedge clk);
            check_out(req_name(VEC[i][15:12]), VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
            check_shape();
        end

        // R5: no change before the clock edge, change one edge later
        carrier_rising = 1'b0;
        #1;
        check_out("R5", 3'b110, 3'd3, 1'b0);
        @(negedge clk);
        check_out("R5", 3'b011, 3'd4, 1'b0);

        // R3: clamp of sextant 4 (phase c, positive rail) held across halves
        sextant = 3'd4;
        carrier_rising = 1'b1;
        @(negedge clk);
        check_out("R3", 3'b101, 3'd5, 1'b0);
        carrier_rising = 1'b0;
        @(negedge clk);
        check_out("R3", 3'b110, 3'd6, 1'b0);

        // R9: reset in the middle of operation clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R9", 3'b000, 3'd0, 1'b0);
        rst_n = 1'b1;
        carrier_rising = 1'b1;
        @(negedge clk);
        check_out("R9", 3'b000, 3'd0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule